// File: doc/BRIEF.md
# CSR Access Execution Unit

This block carries out control and status register accesses for a processor core. It takes one 32-bit instruction word per cycle together with the value of its first source register. If the word is a SYSTEM-class CSR access, the unit performs the atomic read-modify-write against a small local bank of registers. The result for the destination register, the side-effect pulses and any illegal-instruction indication all appear combinationally in the same cycle. Register updates take effect at the next rising clock edge.

The bank holds four read/write scratch registers, one read-only identification register and a retired-instruction counter. The scratch registers have a parameterised writable-bit mask, and bits outside the mask stay zero. The counter advances on every retire pulse. An explicit write to the counter in the same cycle takes the place of that increment.

The access kind is decoded from the low two bits of funct3 into NONE, WRITE, SET or CLEAR. funct3 bit 2 selects the immediate operand. The decoded kind then picks the update function and decides whether a read and a write take place.

Top module: `csr_access_unit`

## Requirements
- R1: While rst_n is low, all scratch registers and the counter are cleared to zero. While instr_valid is low, rd_we, csr_rd_strobe, csr_wr_strobe and illegal_instr are all low.
- R2: Fields are taken as follows: CSR address in bits 31:20, source index or immediate in 19:15, funct3 in 14:12, destination index in 11:7 and opcode in 6:0. An access requires opcode 7'b1110011. funct3 001/010/011 select write/set/clear with a register operand, and 101/110/111 select the same kinds with an immediate. funct3 000 and 100, or any other opcode, are ignored: no output asserts and no register changes.
- R3: A write-kind access stores the operand into the CSR and raises csr_wr_strobe. When the destination index is zero, it raises neither csr_rd_strobe nor rd_we.
- R4: A set access stores old OR operand, and a clear access stores old AND NOT operand. Only writable bits change. In the scratch registers, bits 31:28 are not writable and always read as zero.
- R5: Set and clear accesses always raise csr_rd_strobe. They write nothing and raise no csr_wr_strobe when the source index field is zero. A nonzero source index whose register value is zero still raises csr_wr_strobe.
- R6: Immediate forms use bits 19:15 zero-extended to XLEN as the operand, in place of rs1_value.
- R7: On a legal access, rd_data carries the CSR contents from before the instruction. rd_we is high when a read occurs and the destination index is nonzero. rd_idx echoes bits 11:7. When no read occurs, rd_data is zero.
- R8: An address with bits 11:10 equal to 2'b11 is read-only. A write attempt to it raises illegal_instr. A set or clear access whose write is suppressed by R5 is a legal read.
- R9: Addresses other than 0x340–0x343 (scratch), 0xB02 (counter) and 0xF11 (identification, reads 0x5A170001) raise illegal_instr. Any illegal access gives no rd_we, no strobes and no register update.
- R10: The counter increments by one at each clock edge where retire is high. A committed write to the counter in that cycle replaces the increment, and a read in that cycle returns the value before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_value | input | XLEN | Value of the source register |
| retire | input | 1 | An instruction retires this cycle |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Old CSR value for the destination |
| csr_rd_strobe | output | 1 | Read side-effect pulse |
| csr_wr_strobe | output | 1 | Write side-effect pulse |
| illegal_instr | output | 1 | Illegal-instruction flag |

## Verification
The assertions check every cycle that an illegal access stays silent on all outputs, and that ignored funct3 values and foreign opcodes produce nothing. They also check that set and clear always read, that a zero source index suppresses their write, and that a write-kind access with a zero destination neither reads nor writes back. Further per-cycle checks cover read-only write attempts flagging illegal and the counter stepping by one when no write targets it. The stored values are visible only through later reads, so only the bench scenarios can show them: the masked set and clear results, immediate zero-extension, and the replacement of the counter increment by a same-cycle write.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_SET   = 2'b10,
        ACC_CLEAR = 2'b11
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic       use_imm;
        logic [11:0] addr;
        logic [4:0] src_idx;
        logic [4:0] dst_idx;
    } csr_op_t;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_unit_pkg::*;
(
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output csr_op_t     op,
    output logic        wants_read,
    output logic        wants_write
);

    always_comb begin
        op.addr    = instr[31:20];
        op.src_idx = instr[19:15];
        op.use_imm = instr[14];
        op.dst_idx = instr[11:7];
        op.kind    = ACC_NONE;
        if (instr_valid && (instr[6:0] == OPC_SYSTEM)) begin
            unique case (instr[13:12])
                2'b01:   op.kind = ACC_WRITE;
                2'b10:   op.kind = ACC_SET;
                2'b11:   op.kind = ACC_CLEAR;
                default: op.kind = ACC_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (op.kind)
            ACC_WRITE: begin
                wants_read  = (op.dst_idx != 5'd0);
                wants_write = 1'b1;
            end
            ACC_SET, ACC_CLEAR: begin
                wants_read  = 1'b1;
                wants_write = (op.src_idx != 5'd0);
            end
            default: begin
                wants_read  = 1'b0;
                wants_write = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csr_update.sv
module csr_update
    import csr_unit_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_kind_e        kind,
    input  logic [XLEN-1:0]  old_value,
    input  logic [XLEN-1:0]  operand,
    input  logic [XLEN-1:0]  wmask,
    output logic [XLEN-1:0]  new_value
);

    logic [XLEN-1:0] eff;

    always_comb begin
        eff = operand & wmask;
        unique case (kind)
            ACC_WRITE: new_value = (old_value & ~wmask) | eff;
            ACC_SET:   new_value = old_value | eff;
            ACC_CLEAR: new_value = old_value & ~eff;
            default:   new_value = old_value;
        endcase
    end

endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
    parameter int                XLEN          = 32,
    parameter int                N_SCRATCH     = 4,
    parameter logic [11:0]       SCRATCH_BASE  = 12'h340,
    parameter logic [11:0]       CNT_ADDR      = 12'hB02,
    parameter logic [11:0]       ID_ADDR       = 12'hF11,
    parameter logic [XLEN-1:0]   ID_VALUE      = XLEN'(32'h5A17_0001),
    parameter logic [XLEN-1:0]   SCRATCH_WMASK = {4'h0, {(XLEN-4){1'b1}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      addr,
    input  logic             commit_wr,
    input  logic [XLEN-1:0]  wr_value,
    input  logic             retire,
    output logic             hit,
    output logic             read_only,
    output logic [XLEN-1:0]  rdata,
    output logic [XLEN-1:0]  wmask,
    output logic [XLEN-1:0]  cnt_value
);

    logic [N_SCRATCH-1:0] scr_sel;
    logic                 cnt_sel;
    logic                 id_sel;
    logic [XLEN-1:0]      scr_q [N_SCRATCH];
    logic [XLEN-1:0]      cnt_q;

    for (genvar g = 0; g < N_SCRATCH; g++) begin : g_sel
        assign scr_sel[g] = (addr == SCRATCH_BASE + 12'(g));
    end

    assign cnt_sel   = (addr == CNT_ADDR);
    assign id_sel    = (addr == ID_ADDR);
    assign hit       = (|scr_sel) | cnt_sel | id_sel;
    assign read_only = (addr[11:10] == 2'b11);
    assign cnt_value = cnt_q;

    always_comb begin
        rdata = '0;
        wmask = '0;
        for (int i = 0; i < N_SCRATCH; i++) begin
            if (scr_sel[i]) begin
                rdata = scr_q[i];
                wmask = SCRATCH_WMASK;
            end
        end
        if (cnt_sel) begin
            rdata = cnt_q;
            wmask = '1;
        end
        if (id_sel) begin
            rdata = ID_VALUE;
            wmask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SCRATCH; i++) scr_q[i] <= '0;
        end else if (commit_wr) begin
            for (int i = 0; i < N_SCRATCH; i++) begin
                if (scr_sel[i]) scr_q[i] <= wr_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (commit_wr && cnt_sel) begin
            cnt_q <= wr_value;
        end else if (retire) begin
            cnt_q <= cnt_q + XLEN'(1);
        end
    end

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_unit_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [11:0] CNT_ADDR = 12'hB02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rs1_value,
    input  logic             retire,
    output logic             rd_we,
    output logic [4:0]       rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             csr_rd_strobe,
    output logic             csr_wr_strobe,
    output logic             illegal_instr
);

    csr_op_t         op;
    logic            wants_read;
    logic            wants_write;
    logic            is_access;
    logic            legal;
    logic            hit;
    logic            read_only;
    logic            commit_wr;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] old_value;
    logic [XLEN-1:0] new_value;
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] cnt_value;

    csr_decode i_decode (
        .instr_valid (instr_valid),
        .instr       (instr),
        .op          (op),
        .wants_read  (wants_read),
        .wants_write (wants_write)
    );

    csr_bank #(.XLEN(XLEN), .CNT_ADDR(CNT_ADDR)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (op.addr),
        .commit_wr (commit_wr),
        .wr_value  (new_value),
        .retire    (retire),
        .hit       (hit),
        .read_only (read_only),
        .rdata     (old_value),
        .wmask     (wmask),
        .cnt_value (cnt_value)
    );

    assign operand = op.use_imm ? XLEN'(op.src_idx) : rs1_value;

    csr_update #(.XLEN(XLEN)) i_update (
        .kind      (op.kind),
        .old_value (old_value),
        .operand   (operand),
        .wmask     (wmask),
        .new_value (new_value)
    );

    assign is_access     = (op.kind != ACC_NONE);
    assign illegal_instr = is_access && (!hit || (wants_write && read_only));
    assign legal         = is_access && !illegal_instr;
    assign commit_wr     = legal && wants_write;

    assign csr_rd_strobe = legal && wants_read;
    assign csr_wr_strobe = commit_wr;
    assign rd_we         = csr_rd_strobe && (op.dst_idx != 5'd0);
    assign rd_idx        = op.dst_idx;
    assign rd_data       = csr_rd_strobe ? old_value : '0;

endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
    parameter int          XLEN     = 32,
    parameter logic [11:0] CNT_ADDR = 12'hB02
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [31:0]      instr,
    input logic             retire,
    input logic             rd_we,
    input logic [XLEN-1:0]  rd_data,
    input logic             csr_rd_strobe,
    input logic             csr_wr_strobe,
    input logic             illegal_instr,
    input logic [XLEN-1:0]  cnt_value
);

    logic sys_op;
    logic [1:0] kind_bits;
    assign sys_op    = instr_valid && (instr[6:0] == 7'b1110011);
    assign kind_bits = instr[13:12];

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> (!rd_we && !csr_rd_strobe && !csr_wr_strobe));

    assert_ignored_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_op || kind_bits == 2'b00)
        |-> (!rd_we && !csr_rd_strobe && !csr_wr_strobe && !illegal_instr));

    assert_setclr_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_op && kind_bits[1] && !illegal_instr) |-> csr_rd_strobe);

    assert_setclr_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_op && kind_bits[1] && instr[19:15] == 5'd0) |-> !csr_wr_strobe);

    assert_write_x0_noread_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_op && kind_bits == 2'b01 && instr[11:7] == 5'd0)
        |-> (!csr_rd_strobe && !rd_we));

    assert_ro_write_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_op && kind_bits != 2'b00 && instr[31:30] == 2'b11
         && (kind_bits == 2'b01 || instr[19:15] != 5'd0)) |-> illegal_instr);

    assert_no_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd_strobe |-> (rd_data == '0));

    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && retire && !(csr_wr_strobe && instr[31:20] == CNT_ADDR))
        |=> (cnt_value == $past(cnt_value) + XLEN'(1)));

endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN), .CNT_ADDR(CNT_ADDR)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr         (instr),
    .retire        (retire),
    .rd_we         (rd_we),
    .rd_data       (rd_data),
    .csr_rd_strobe (csr_rd_strobe),
    .csr_wr_strobe (csr_wr_strobe),
    .illegal_instr (illegal_instr),
    .cnt_value     (cnt_value)
);

// File: tb/test_csr_access_unit.sv
module test_csr_access_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_value = '0;
    logic        retire = 1'b0;
    logic        rd_we;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic        csr_rd_strobe;
    logic        csr_wr_strobe;
    logic        illegal_instr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_scr [4];
    logic [31:0] m_cnt;
    logic [31:0] got_rd;

    localparam logic [31:0] WMASK = 32'h0FFF_FFFF;
    localparam logic [31:0] IDV   = 32'h5A17_0001;

    always #5 clk = ~clk;

    csr_access_unit i_csr_access_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr         (instr),
        .rs1_value     (rs1_value),
        .retire        (retire),
        .rd_we         (rd_we),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data),
        .csr_rd_strobe (csr_rd_strobe),
        .csr_wr_strobe (csr_wr_strobe),
        .illegal_instr (illegal_instr)
    );

    function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                       input logic [2:0] f, input logic [4:0] d);
        return {a, s, f, d, 7'b1110011};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] r1,
                        input bit ret, input string tag);
        logic        acc, hit, ro, wr_k, st_k, wr, rd, ill, legal;
        logic [11:0] a;
        logic [31:0] old, wm, opnd, nv;
        logic [31:0] got, exp;
        int          idx;
        @(negedge clk);
        instr_valid = v;
        instr       = ins;
        rs1_value   = r1;
        retire      = ret;
        #1;
        a    = ins[31:20];
        acc  = v && ins[6:0] == 7'b1110011 && ins[13:12] != 2'b00;
        idx  = -1;
        hit  = 1'b1;
        old  = '0;
        wm   = '0;
        if (a >= 12'h340 && a <= 12'h343) begin
            idx = int'(a - 12'h340); old = m_scr[idx]; wm = WMASK;
        end else if (a == 12'hB02) begin
            old = m_cnt; wm = '1;
        end else if (a == 12'hF11) begin
            old = IDV;
        end else begin
            hit = 1'b0;
        end
        ro    = a[11:10] == 2'b11;
        wr_k  = ins[13:12] == 2'b01;
        st_k  = ins[13:12] == 2'b10;
        rd    = wr_k ? (ins[11:7] != 0) : 1'b1;
        wr    = wr_k ? 1'b1 : (ins[19:15] != 0);
        ill   = acc && (!hit || (wr && ro));
        legal = acc && !ill;
        opnd  = ins[14] ? {27'd0, ins[19:15]} : r1;
        if (wr_k)      nv = (old & ~wm) | (opnd & wm);
        else if (st_k) nv = old | (opnd & wm);
        else           nv = old & ~(opnd & wm);
        got = {rd_data};
        exp = (legal && rd) ? old : 32'd0;
        check(tag, got, exp);
        got = {27'd0, rd_we, csr_rd_strobe, csr_wr_strobe, illegal_instr, 1'b0};
        exp = {27'd0, legal && rd && ins[11:7] != 0, legal && rd, legal && wr, ill, 1'b0};
        check(tag, got, exp);
        got_rd = rd_data;
        if (legal && wr) begin
            if (idx >= 0) m_scr[idx] = nv;
            else if (a == 12'hB02) m_cnt = nv;
        end
        if (ret && !(legal && wr && a == 12'hB02)) m_cnt = m_cnt + 1;
    endtask

    function automatic string tag_of(input logic [31:0] ins, input bit v);
        logic [11:0] a = ins[31:20];
        if (!v || ins[6:0] != 7'b1110011 || ins[13:12] == 2'b00) return "R2";
        if (!((a >= 12'h340 && a <= 12'h343) || a == 12'hB02 || a == 12'hF11)) return "R9";
        if (a == 12'hF11) return "R8";
        if (a == 12'hB02) return "R10";
        if (ins[14]) return "R6";
        if (ins[13:12] == 2'b01) return "R3";
        return "R4";
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) m_scr[i] = '0;
        m_cnt = '0;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1: reset state, valid low produces nothing
        check("R1", {28'd0, rd_we, csr_rd_strobe, csr_wr_strobe, illegal_instr}, 32'd0);
        rst_n = 1'b1;
        step(1'b0, mk(12'h340, 5'd3, 3'b001, 5'd1), 32'hFFFF_FFFF, 1'b0, "R1");
        for (int i = 0; i < 4; i++) begin
            step(1'b1, mk(12'h340 + 12'(i), 5'd0, 3'b010, 5'd1), 32'd0, 1'b0, "R1");
            check("R1", got_rd, 32'd0);
        end
        // R4: writable mask on scratch registers
        step(1'b1, mk(12'h340, 5'd2, 3'b001, 5'd0), 32'hFFFF_FFFF, 1'b0, "R3");
        step(1'b1, mk(12'h340, 5'd0, 3'b010, 5'd4), 32'd0, 1'b0, "R4");
        check("R4", got_rd, 32'h0FFF_FFFF);
        // R4: clear then set
        step(1'b1, mk(12'h340, 5'd5, 3'b011, 5'd1), 32'h00FF_00FF, 1'b0, "R4");
        check("R7", got_rd, 32'h0FFF_FFFF);
        step(1'b1, mk(12'h340, 5'd5, 3'b010, 5'd1), 32'hF000_0001, 1'b0, "R4");
        check("R4", got_rd, 32'h0F00_FF00);
        step(1'b1, mk(12'h340, 5'd0, 3'b010, 5'd1), 32'd0, 1'b0, "R4");
        check("R4", got_rd, 32'h0F00_FF01);
        // R5: nonzero index holding zero still writes; zero index does not
        step(1'b1, mk(12'h341, 5'd7, 3'b010, 5'd0), 32'd0, 1'b0, "R5");
        step(1'b1, mk(12'h341, 5'd0, 3'b011, 5'd0), 32'hFFFF_FFFF, 1'b0, "R5");
        // R6: immediate forms zero-extend
        step(1'b1, mk(12'h342, 5'd31, 3'b101, 5'd2), 32'hDEAD_BEEF, 1'b0, "R6");
        step(1'b1, mk(12'h342, 5'd1, 3'b111, 5'd2), 32'hFFFF_FFFF, 1'b0, "R6");
        check("R6", got_rd, 32'd31);
        step(1'b1, mk(12'h342, 5'd0, 3'b110, 5'd2), 32'd0, 1'b0, "R6");
        check("R6", got_rd, 32'd30);
        // R8: read-only register
        step(1'b1, mk(12'hF11, 5'd0, 3'b010, 5'd3), 32'd0, 1'b0, "R8");
        check("R8", got_rd, IDV);
        step(1'b1, mk(12'hF11, 5'd0, 3'b001, 5'd3), 32'd0, 1'b0, "R8");
        step(1'b1, mk(12'hF11, 5'd4, 3'b110, 5'd3), 32'd0, 1'b0, "R8");
        // R9: unimplemented address
        step(1'b1, mk(12'h7C0, 5'd1, 3'b001, 5'd3), 32'h1234, 1'b0, "R9");
        // R2: ignored funct3 values and foreign opcode
        step(1'b1, mk(12'h340, 5'd1, 3'b000, 5'd3), 32'h1, 1'b0, "R2");
        step(1'b1, mk(12'h340, 5'd1, 3'b100, 5'd3), 32'h1, 1'b0, "R2");
        step(1'b1, {12'h340, 5'd1, 3'b001, 5'd3, 7'b0010011}, 32'h1, 1'b0, "R2");
        // R10: counter increment, write replaces increment
        step(1'b1, mk(12'hB02, 5'd0, 3'b010, 5'd1), 32'd0, 1'b1, "R10");
        check("R10", got_rd, 32'd0);
        step(1'b1, mk(12'hB02, 5'd0, 3'b010, 5'd1), 32'd0, 1'b1, "R10");
        check("R10", got_rd, 32'd1);
        step(1'b1, mk(12'hB02, 5'd1, 3'b001, 5'd1), 32'd100, 1'b1, "R10");
        check("R10", got_rd, 32'd2);
        step(1'b1, mk(12'hB02, 5'd0, 3'b010, 5'd1), 32'd0, 1'b0, "R10");
        check("R10", got_rd, 32'd100);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [4:0]  s, d;
            logic [31:0] ins, r1;
            bit          v;
            case ($urandom % 8)
                0: a = 12'h340; 1: a = 12'h341; 2: a = 12'h342; 3: a = 12'h343;
                4: a = 12'hB02; 5: a = 12'hF11; 6: a = 12'h7C0; default: a = 12'h344;
            endcase
            s   = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
            d   = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
            ins = mk(a, s, 3'($urandom), d);
            if ($urandom % 16 == 0) ins[6:0] = 7'b0010011;
            r1  = ($urandom % 4 == 0) ? 32'd0 : $urandom;
            v   = ($urandom % 10 != 0);
            step(v, ins, r1, 1'($urandom), tag_of(ins, v));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule